// File: doc/BRIEF.md
# Effective Address Generation Unit

This block resolves the operand of a load-to-accumulator instruction. It receives the mode code and the address field of an instruction. It then produces the effective address and the operand word that would be loaded. It holds four architectural registers: the program counter, a general register R1, an index register and a base register. It reaches a word-addressed memory through a synchronous read port, with read data returned one cycle after the request.

A start pulse launches one resolution. A single-cycle done pulse marks the cycle in which the effective address, the operand and the illegal-mode flag are valid. Modes that need no memory finish in one cycle, modes that read the operand from memory finish in three, and the indirect mode, which first fetches the pointer word, finishes in five. The program counter is taken to hold the address of the two-word instruction being resolved, and it steps past that instruction on completion. A write port loads any of the four registers while the unit is idle.

Top module: `eff_addr_gen`

## Requirements
- R1: After reset, done_o, illegal_o and mem_rd_o are 0, and ea_o, operand_o, pc_o and r1_o are 0.
- R2: Mode 0 (immediate) gives effective address PC+1 and takes the operand from the address field. It makes no memory access, and done_o rises in the cycle after the start edge.
- R3: Mode 1 (direct) uses the address field as the effective address, with done_o 3 cycles after start. Mode 2 (indirect) reads memory at the address field and uses that word as the effective address, with done_o 5 cycles after start. Every memory-reading mode returns as operand the memory word at the effective address.
- R4: Mode 3 (register) returns R1 as the operand and 0 as the effective address, with done_o 1 cycle after start and no memory access.
- R5: Mode 4 (register indirect) and mode 5 (autoincrement) use R1 as the effective address. Mode 5 then leaves R1 incremented by one.
- R6: Mode 6 (autodecrement) decrements R1 first and uses the decremented value as the effective address.
- R7: Mode 7 (relative) uses PC+2, the counter after instruction fetch, plus the address field as the effective address.
- R8: Mode 8 (indexed) adds the index register to the address field, and mode 9 (base) adds the base register to it.
- R9: All address arithmetic wraps modulo 2^W (W=12 by default).
- R10: Mode codes 10 to 15 are illegal. They give done_o after 1 cycle with illegal_o=1 and ea_o=operand_o=0, and they leave PC and R1 unchanged.
- R11: done_o is a one-cycle pulse. A start_i received while a resolution is in progress has no effect on that result.
- R12: Every legal resolution advances PC by 2 at the done cycle.
- R13: With wr_en_i high while idle, wr_sel_i selects the register (0 PC, 1 R1, 2 index, 3 base) that takes wr_data_i at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin resolution (accepted when idle) |
| mode_i | input | 4 | Addressing mode code |
| addr_i | input | W | Address field of the instruction |
| wr_en_i | input | 1 | Register write enable |
| wr_sel_i | input | 2 | Register select for writes |
| wr_data_i | input | W | Register write data |
| mem_rd_o | output | 1 | Memory read request |
| mem_addr_o | output | W | Memory read address |
| mem_rdata_i | input | W | Memory read data, one cycle after request |
| ea_o | output | W | Effective address |
| operand_o | output | W | Operand for the load |
| done_o | output | 1 | Result valid pulse |
| illegal_o | output | 1 | Illegal mode code, valid with done_o |
| pc_o | output | W | Program counter |
| r1_o | output | W | Register R1 |

## Verification
The assertions rely on three assumptions about the surroundings. The memory must answer every read request with data in the following cycle. Register writes must not coincide with an accepted start when the R1 update checks apply. start_i is sampled only while idle. The stimulus satisfies these by driving all inputs at the falling edge and by issuing writes only between resolutions. The memory model always returns registered data one cycle after a request. The one deliberate start during a busy resolution checks that it is ignored.

// File: rtl/eag_pkg.sv
package eag_pkg;
  typedef enum logic [3:0] {
    M_IMM  = 4'd0,
    M_DIR  = 4'd1,
    M_IND  = 4'd2,
    M_REG  = 4'd3,
    M_RIND = 4'd4,
    M_AINC = 4'd5,
    M_ADEC = 4'd6,
    M_REL  = 4'd7,
    M_IDX  = 4'd8,
    M_BASE = 4'd9
  } mode_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_IND_REQ,
    S_IND_CAP,
    S_OP_REQ,
    S_OP_CAP,
    S_FIN
  } state_e;
endpackage

// File: rtl/eag_regs.sv
module eag_regs #(
  parameter int unsigned W           = 12,
  parameter int unsigned NREG        = 4,
  parameter int unsigned INSTR_WORDS = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_en_i,
  input  logic [$clog2(NREG)-1:0] wr_sel_i,
  input  logic [W-1:0]            wr_data_i,
  input  logic                    pc_adv_i,
  input  logic                    r1_upd_i,
  input  logic [W-1:0]            r1_val_i,
  output logic [W-1:0]            pc_o,
  output logic [W-1:0]            r1_o,
  output logic [W-1:0]            xr_o,
  output logic [W-1:0]            br_o
);
  localparam int unsigned SW = $clog2(NREG);
  localparam logic [W-1:0] PC_STEP = W'(INSTR_WORDS);
  localparam int unsigned IDX_PC = 0;
  localparam int unsigned IDX_R1 = 1;

  logic [W-1:0] regs_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        regs_q[g] <= '0;
      end else if (wr_en_i && wr_sel_i == SW'(g)) begin
        regs_q[g] <= wr_data_i;
      end else if (g == IDX_PC && pc_adv_i) begin
        regs_q[g] <= regs_q[g] + PC_STEP;
      end else if (g == IDX_R1 && r1_upd_i) begin
        regs_q[g] <= r1_val_i;
      end
    end
  end

  assign pc_o = regs_q[0];
  assign r1_o = regs_q[1];
  assign xr_o = regs_q[2];
  assign br_o = regs_q[3];
endmodule

// File: rtl/eag_ea_calc.sv
module eag_ea_calc
  import eag_pkg::*;
#(
  parameter int unsigned W           = 12,
  parameter int unsigned INSTR_WORDS = 2
) (
  input  logic [3:0]   mode_i,
  input  logic [W-1:0] addr_i,
  input  logic [W-1:0] pc_i,
  input  logic [W-1:0] r1_i,
  input  logic [W-1:0] xr_i,
  input  logic [W-1:0] br_i,
  output logic [W-1:0] ea_o,
  output logic [W-1:0] imm_o,
  output logic         r1_upd_o,
  output logic [W-1:0] r1_val_o,
  output logic         use_mem_o,
  output logic         indirect_o,
  output logic         illegal_o
);
  localparam logic [W-1:0] ONE     = W'(1);
  localparam logic [W-1:0] PC_NEXT = W'(INSTR_WORDS);

  always_comb begin
    ea_o       = '0;
    imm_o      = '0;
    r1_upd_o   = 1'b0;
    r1_val_o   = r1_i;
    use_mem_o  = 1'b1;
    indirect_o = 1'b0;
    illegal_o  = 1'b0;
    case (mode_i)
      M_IMM: begin
        ea_o      = pc_i + ONE;
        imm_o     = addr_i;
        use_mem_o = 1'b0;
      end
      M_DIR:  ea_o = addr_i;
      M_IND:  indirect_o = 1'b1;  // pointer fetched by the sequencer
      M_REG: begin
        imm_o     = r1_i;
        use_mem_o = 1'b0;
      end
      M_RIND: ea_o = r1_i;
      M_AINC: begin
        ea_o     = r1_i;
        r1_upd_o = 1'b1;
        r1_val_o = r1_i + ONE;
      end
      M_ADEC: begin
        ea_o     = r1_i - ONE;
        r1_upd_o = 1'b1;
        r1_val_o = r1_i - ONE;
      end
      M_REL:  ea_o = pc_i + PC_NEXT + addr_i;
      M_IDX:  ea_o = xr_i + addr_i;
      M_BASE: ea_o = br_i + addr_i;
      default: begin
        illegal_o = 1'b1;
        use_mem_o = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/eag_seq.sv
module eag_seq
  import eag_pkg::*;
#(
  parameter int unsigned W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] addr_i,
  input  logic [W-1:0] calc_ea_i,
  input  logic [W-1:0] imm_i,
  input  logic         use_mem_i,
  input  logic         indirect_i,
  input  logic         illegal_i,
  input  logic [W-1:0] mem_rdata_i,
  output logic         idle_o,
  output logic         mem_rd_o,
  output logic [W-1:0] mem_addr_o,
  output logic [W-1:0] ea_o,
  output logic [W-1:0] operand_o,
  output logic         done_o,
  output logic         illegal_o,
  output logic         pc_adv_o
);
  state_e       state_q;
  logic [W-1:0] addr_q, ea_q, op_q;
  logic         ill_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      addr_q  <= '0;
      ea_q    <= '0;
      op_q    <= '0;
      ill_q   <= 1'b0;
    end else begin
      case (state_q)
        S_IDLE: if (start_i) begin
          addr_q <= addr_i;
          ill_q  <= illegal_i;
          ea_q   <= calc_ea_i;
          op_q   <= imm_i;
          if (illegal_i || !use_mem_i) state_q <= S_FIN;
          else if (indirect_i)         state_q <= S_IND_REQ;
          else                         state_q <= S_OP_REQ;
        end
        S_IND_REQ: state_q <= S_IND_CAP;
        S_IND_CAP: begin
          ea_q    <= mem_rdata_i;
          state_q <= S_OP_REQ;
        end
        S_OP_REQ: state_q <= S_OP_CAP;
        S_OP_CAP: begin
          op_q    <= mem_rdata_i;
          state_q <= S_FIN;
        end
        S_FIN:   state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign idle_o     = (state_q == S_IDLE);
  assign mem_rd_o   = (state_q == S_IND_REQ) || (state_q == S_OP_REQ);
  assign mem_addr_o = (state_q == S_IND_REQ) ? addr_q : ea_q;
  assign ea_o       = ea_q;
  assign operand_o  = op_q;
  assign done_o     = (state_q == S_FIN);
  assign illegal_o  = done_o && ill_q;
  assign pc_adv_o   = done_o && !ill_q;

  // R11
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R3
  mem_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o |=> !mem_rd_o && !done_o);
endmodule

// File: rtl/eff_addr_gen.sv
module eff_addr_gen
  import eag_pkg::*;
#(
  parameter int unsigned W           = 12,
  parameter int unsigned INSTR_WORDS = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [3:0]   mode_i,
  input  logic [W-1:0] addr_i,
  input  logic         wr_en_i,
  input  logic [1:0]   wr_sel_i,
  input  logic [W-1:0] wr_data_i,
  output logic         mem_rd_o,
  output logic [W-1:0] mem_addr_o,
  input  logic [W-1:0] mem_rdata_i,
  output logic [W-1:0] ea_o,
  output logic [W-1:0] operand_o,
  output logic         done_o,
  output logic         illegal_o,
  output logic [W-1:0] pc_o,
  output logic [W-1:0] r1_o
);
  localparam int unsigned NREG = 4;
  localparam logic [W-1:0] PC_STEP = W'(INSTR_WORDS);

  logic [W-1:0] xr, br, calc_ea, imm, r1_val;
  logic         r1_upd, use_mem, indirect, calc_ill, idle, pc_adv;

  eag_ea_calc #(.W(W), .INSTR_WORDS(INSTR_WORDS)) calc_i (
    .mode_i(mode_i), .addr_i(addr_i), .pc_i(pc_o), .r1_i(r1_o),
    .xr_i(xr), .br_i(br), .ea_o(calc_ea), .imm_o(imm),
    .r1_upd_o(r1_upd), .r1_val_o(r1_val), .use_mem_o(use_mem),
    .indirect_o(indirect), .illegal_o(calc_ill)
  );

  eag_regs #(.W(W), .NREG(NREG), .INSTR_WORDS(INSTR_WORDS)) regs_i (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_en_i(wr_en_i && idle), .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i),
    .pc_adv_i(pc_adv), .r1_upd_i(r1_upd && idle && start_i),
    .r1_val_i(r1_val), .pc_o(pc_o), .r1_o(r1_o), .xr_o(xr), .br_o(br)
  );

  eag_seq #(.W(W)) seq_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .addr_i(addr_i),
    .calc_ea_i(calc_ea), .imm_i(imm), .use_mem_i(use_mem),
    .indirect_i(indirect), .illegal_i(calc_ill), .mem_rdata_i(mem_rdata_i),
    .idle_o(idle), .mem_rd_o(mem_rd_o), .mem_addr_o(mem_addr_o),
    .ea_o(ea_o), .operand_o(operand_o), .done_o(done_o),
    .illegal_o(illegal_o), .pc_adv_o(pc_adv)
  );

  // R12
  pc_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !illegal_o |=> pc_o == $past(pc_o) + PC_STEP);

  // R10
  illegal_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && illegal_o |=> pc_o == $past(pc_o) && r1_o == $past(r1_o));

  // R5
  ainc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && idle && !wr_en_i && mode_i == M_AINC |=> r1_o == $past(r1_o) + W'(1));

  // R6
  adec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && idle && !wr_en_i && mode_i == M_ADEC |=> r1_o == $past(r1_o) - W'(1));

  // R2
  fast_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && idle && (mode_i == M_IMM || mode_i == M_REG || mode_i > 4'd9)
    |=> done_o && !mem_rd_o);
endmodule

// File: tb/eff_addr_gen_tb_top.sv
`timescale 1ns/1ps
module eff_addr_gen_tb_top;
  localparam int W = 12;

  typedef struct packed {
    logic [W-1:0] ea;
    logic [W-1:0] op;
    logic         ill;
    logic [31:0]  lat;
    logic [31:0]  t0;
  } exp_t;

  logic         clk = 1'b0, rst_n = 1'b0;
  logic         start = 1'b0, wr_en = 1'b0;
  logic [3:0]   mode = '0;
  logic [1:0]   wr_sel = '0;
  logic [W-1:0] addr = '0, wr_data = '0, mem_rdata = '0;
  logic         mem_rd, done, illegal;
  logic [W-1:0] mem_addr, ea, operand, pc, r1;

  logic [W-1:0] mem [4096];
  logic [W-1:0] m_pc, m_r1, m_xr, m_br;
  exp_t  exp_q[$];
  string req_q[$];
  int    cyc = 0, n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(posedge clk) if (mem_rd) mem_rdata <= mem[mem_addr];

  eff_addr_gen #(.W(W), .INSTR_WORDS(2)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_i(mode), .addr_i(addr),
    .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
    .mem_rd_o(mem_rd), .mem_addr_o(mem_addr), .mem_rdata_i(mem_rdata),
    .ea_o(ea), .operand_o(operand), .done_o(done), .illegal_o(illegal),
    .pc_o(pc), .r1_o(r1)
  );

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] sel, logic [W-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    case (sel)
      2'd0: m_pc = d;
      2'd1: m_r1 = d;
      2'd2: m_xr = d;
      default: m_br = d;
    endcase
  endtask

  // driver: model the expected result, queue it, then apply the stimulus
  task automatic run(string req, int md, logic [W-1:0] a, bit poke);
    exp_t e;
    int   n;
    e = '0;
    e.lat = 3;
    case (md)
      0: begin e.ea = m_pc + 1; e.op = a; e.lat = 1; end
      1: e.ea = a;
      2: begin e.ea = mem[a]; e.lat = 5; end
      3: begin e.ea = '0; e.op = m_r1; e.lat = 1; end
      4: e.ea = m_r1;
      5: begin e.ea = m_r1; m_r1 = m_r1 + 1; end
      6: begin m_r1 = m_r1 - 1; e.ea = m_r1; end
      7: e.ea = m_pc + 2 + a;
      8: e.ea = m_xr + a;
      9: e.ea = m_br + a;
      default: begin e.ill = 1'b1; e.lat = 1; end
    endcase
    if (!e.ill && md != 0 && md != 3) e.op = mem[e.ea];
    if (!e.ill) m_pc = m_pc + 2;
    @(negedge clk);
    e.t0 = cyc;
    exp_q.push_back(e);
    req_q.push_back(req);
    start = 1'b1; mode = 4'(md); addr = a;
    n = 0;
    do begin
      @(negedge clk);
      if (n == 0 && poke) begin
        start = 1'b1; mode = 4'd3; addr = '0;  // must be ignored while busy
      end else begin
        start = 1'b0;
      end
      n++;
    end while (!done && n < 40);
    start = 1'b0;
    if (!done) check("R11", "watchdog: done never seen", 0, 1);
    @(negedge clk);
    check(req, "pc after", pc, m_pc);
    check(req, "r1 after", r1, m_r1);
  endtask

  // monitor: compare each completion against the scoreboard
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (exp_q.size() == 0) begin
        check("R11", "unexpected done", 1, 0);
      end else begin
        exp_t  e;
        string rq;
        e  = exp_q.pop_front();
        rq = req_q.pop_front();
        check(rq, "ea", ea, e.ea);
        check(rq, "operand", operand, e.op);
        check(rq, "illegal", illegal, e.ill);
        check(rq, "latency", cyc - e.t0, e.lat);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    check("R11", "global watchdog", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = W'(i * 7 + 3);
    mem[201] = 500; mem[500] = 800; mem[800] = 300; mem[400] = 700;
    mem[702] = 325; mem[600] = 900; mem[399] = 450;
    m_pc = '0; m_r1 = '0; m_xr = '0; m_br = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "done", done, 0);
    check("R1", "illegal", illegal, 0);
    check("R1", "mem_rd", mem_rd, 0);
    check("R1", "ea", ea, 0);
    check("R1", "operand", operand, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "pc", pc, 0);
    check("R1", "r1", r1, 0);

    // R13 register writes seen at the ports
    wr(2'd0, 200); check("R13", "pc write", pc, 200);
    wr(2'd1, 400); check("R13", "r1 write", r1, 400);
    wr(2'd2, 100);
    wr(2'd3, 300);

    run("R2", 0, 500, 0);
    wr(2'd0, 200); run("R3", 1, 500, 0);
    wr(2'd0, 200); run("R3", 2, 500, 0);
    wr(2'd0, 200); run("R4", 3, 500, 0);
    wr(2'd0, 200); run("R5", 4, 500, 0);
    wr(2'd0, 200); run("R7", 7, 500, 0);
    wr(2'd0, 200); run("R8", 8, 500, 0);
    wr(2'd0, 200); run("R8", 9, 500, 0);
    wr(2'd0, 200); run("R5", 5, 500, 0);
    wr(2'd1, 400); run("R6", 6, 500, 0);

    // R12 back-to-back advance without rewriting PC
    run("R12", 1, 10, 0);
    run("R12", 4, 11, 0);

    // R9 wrap-around
    wr(2'd0, 4095); run("R9", 0, 7, 0);
    wr(2'd0, 4000); run("R9", 7, 200, 0);
    wr(2'd2, 4000); run("R9", 8, 100, 0);
    wr(2'd1, 0);    run("R9", 6, 0, 0);
    wr(2'd1, 4095); run("R9", 5, 0, 0);

    // R10 illegal codes
    for (int m = 10; m < 16; m++) run("R10", m, 123, 0);

    // R11 start while busy is ignored
    wr(2'd1, 400);
    run("R11", 2, 500, 1);
    run("R11", 1, 600, 1);

    repeat (4) @(negedge clk);
    check("R11", "queue drained", exp_q.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule